// File: doc/BRIEF.md
# Processor trap entry controller

This block gathers the exception and interrupt request lines of a simple processor pipeline and performs every state change needed to enter a trap. It handles software trap instructions, missing-unlock faults, floating-point faults, instruction-fetch translation faults, data-access faults and external interrupts. When any accepted request is present, the block emits an abort pulse in that cycle so the pipeline discards the current instruction, which can then be restarted.

On the following clock edge it saves the user-mode and interrupt-enable bits into previous-state bits. It then drops to supervisor mode with interrupts masked, records the program counter of the aborted instruction, and latches a sticky indication bit for each trap class that was requested. One cycle after the abort, it issues a one-cycle redirect of fetch to a fixed handler vector.

Software reads and rewrites the status word through a single write port. Writing the word is the only way to clear indication bits. Hardware reset is not a trap: it sets no indication bit and leaves the processor in supervisor mode with interrupts disabled.

Top module: `trap_entry_ctrl`

## Requirements
- R1: After reset, `user_o`, `irq_en_o`, `prev_user_o` and `prev_irq_en_o` are 0, `trap_ind_o` is all zero, `fault_pc_o` is 0, and `abort_o` and `redirect_o` are 0.
- R2: `abort_o` is 1 in exactly the cycles in which at least one accepted request line is high. It is combinational from the request lines.
- R3: On the clock edge that ends an abort cycle, `prev_user_o` takes the value `user_o` had in that cycle and `prev_irq_en_o` takes the value `irq_en_o` had in that cycle.
- R4: On the same edge, `user_o` and `irq_en_o` become 0.
- R5: On the same edge, `fault_pc_o` takes the value of `pc_i` from the abort cycle.
- R6: `redirect_o` is 1 for exactly the one cycle after each abort cycle. `redirect_pc_o` always equals the parameter `HANDLER_VEC`, which defaults to 0x100.
- R7: Indication bit positions in `trap_ind_o` are: bit 0 software trap, bit 1 missing unlock, bit 2 floating-point fault, bit 3 instruction-fetch translation, bit 4 data access, bit 5 external interrupt. Bit 4 is set by any of `ldst_xlat_i`, `misalign_i` or `dbg_match_i`.
- R8: `ext_irq_i` is accepted only while `irq_en_o` is 1. When it is not accepted, it causes no abort, no redirect and no indication bit.
- R9: When several requests are high in the same cycle, all of their indication bits are set on one edge and only one trap entry occurs, with a single one-cycle redirect.
- R10: Indication bits are sticky and change only through trap entry or a status write. A write with `st_wr_i`=1 loads the status word `st_wdata_i`: bit 0 user, bit 1 interrupt enable, bit 2 previous user, bit 3 previous interrupt enable, bits 9:4 the indication bits in R7 order.
- R11: If a status write and a trap entry fall in the same cycle, the trap's mode changes win. The previous-state bits save the register values from before the edge, not the written values. The indication bits become the written indication field ORed with the new trap's bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sw_trap_i | input | 1 | Software trap instruction request |
| unlock_miss_i | input | 1 | Missing unlock request |
| fp_fault_i | input | 1 | Floating-point fault request |
| ifetch_xlat_i | input | 1 | Instruction-fetch translation fault |
| ldst_xlat_i | input | 1 | Load/store translation fault |
| misalign_i | input | 1 | Misaligned operand address |
| dbg_match_i | input | 1 | Operand address matched debug address |
| ext_irq_i | input | 1 | External interrupt request |
| pc_i | input | PC_W | PC of the instruction in execution |
| st_wr_i | input | 1 | Status word write strobe |
| st_wdata_i | input | 10 | Status word write data |
| user_o | output | 1 | Current user-mode bit |
| irq_en_o | output | 1 | Current interrupt-enable bit |
| prev_user_o | output | 1 | Saved user-mode bit |
| prev_irq_en_o | output | 1 | Saved interrupt-enable bit |
| trap_ind_o | output | 6 | Sticky trap indication bits |
| abort_o | output | 1 | Abort/flush of current instruction |
| fault_pc_o | output | PC_W | PC of aborted instruction |
| redirect_o | output | 1 | Fetch redirect pulse |
| redirect_pc_o | output | PC_W | Handler vector address |

## Verification
A software status write and a trap entry can land on the same clock edge, and both want to update the mode and indication bits. The bench first enters user mode with interrupts enabled. In one cycle it then raises a floating-point fault and writes a status word that keeps user mode on and sets only the missing-unlock bit. The result is judged against R11: supervisor mode with interrupts off, previous bits holding the pre-edge ones, and both the written and the new indication bits set. A second overlap, several request lines high together, is judged by one abort cycle, a single redirect pulse and the union of indication bits.

// File: rtl/trap_entry_pkg.sv
`timescale 1ns/1ps
package trap_entry_pkg;
  localparam int NUM_CLS = 6;
  localparam int CLS_SW   = 0;
  localparam int CLS_LOCK = 1;
  localparam int CLS_FP   = 2;
  localparam int CLS_IXL  = 3;
  localparam int CLS_DACC = 4;
  localparam int CLS_IRQ  = 5;
  localparam int ST_W = 4 + NUM_CLS;

  typedef logic [NUM_CLS-1:0] cls_vec_t;

  typedef struct packed {
    cls_vec_t ind;
    logic     pim;
    logic     pu;
    logic     im;
    logic     u;
  } status_t;
endpackage

// File: rtl/trap_req_collect.sv
`timescale 1ns/1ps
module trap_req_collect
  import trap_entry_pkg::*;
(
  input  logic     sw_trap_i,
  input  logic     unlock_miss_i,
  input  logic     fp_fault_i,
  input  logic     ifetch_xlat_i,
  input  logic     ldst_xlat_i,
  input  logic     misalign_i,
  input  logic     dbg_match_i,
  input  logic     ext_irq_i,
  input  logic     irq_en_i,
  output cls_vec_t hit_o,
  output logic     take_o
);
  always_comb begin
    hit_o           = '0;
    hit_o[CLS_SW]   = sw_trap_i;
    hit_o[CLS_LOCK] = unlock_miss_i;
    hit_o[CLS_FP]   = fp_fault_i;
    hit_o[CLS_IXL]  = ifetch_xlat_i;
    // three distinct data-side faults share one class
    hit_o[CLS_DACC] = ldst_xlat_i | misalign_i | dbg_match_i;
    hit_o[CLS_IRQ]  = ext_irq_i & irq_en_i;
  end

  assign take_o = |hit_o;
endmodule

// File: rtl/trap_status_reg.sv
`timescale 1ns/1ps
module trap_status_reg
  import trap_entry_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     take_i,
  input  cls_vec_t hit_i,
  input  logic     wr_i,
  input  status_t  wdata_i,
  output status_t  status_o
);
  status_t st_q, st_d, base;

  always_comb begin
    base = wr_i ? wdata_i : st_q;
    st_d = base;
    if (take_i) begin
      // save from the pre-edge registers, not the written word
      st_d.pu  = st_q.u;
      st_d.pim = st_q.im;
      st_d.u   = 1'b0;
      st_d.im  = 1'b0;
      st_d.ind = base.ind | hit_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= st_d;
  end

  assign status_o = st_q;
endmodule

// File: rtl/trap_redirect.sv
`timescale 1ns/1ps
module trap_redirect #(
  parameter int              PC_W        = 32,
  parameter logic [PC_W-1:0] HANDLER_VEC = PC_W'('h100)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            take_i,
  input  logic [PC_W-1:0] pc_i,
  output logic [PC_W-1:0] fault_pc_o,
  output logic            redirect_o,
  output logic [PC_W-1:0] redirect_pc_o
);
  logic [PC_W-1:0] fpc_q;
  logic            redir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fpc_q   <= '0;
      redir_q <= 1'b0;
    end else begin
      redir_q <= take_i;
      if (take_i) fpc_q <= pc_i;
    end
  end

  assign fault_pc_o    = fpc_q;
  assign redirect_o    = redir_q;
  assign redirect_pc_o = HANDLER_VEC;
endmodule

// File: rtl/trap_entry_ctrl.sv
`timescale 1ns/1ps
module trap_entry_ctrl
  import trap_entry_pkg::*;
#(
  parameter int              PC_W        = 32,
  parameter logic [PC_W-1:0] HANDLER_VEC = PC_W'('h100)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sw_trap_i,
  input  logic               unlock_miss_i,
  input  logic               fp_fault_i,
  input  logic               ifetch_xlat_i,
  input  logic               ldst_xlat_i,
  input  logic               misalign_i,
  input  logic               dbg_match_i,
  input  logic               ext_irq_i,
  input  logic [PC_W-1:0]    pc_i,
  input  logic               st_wr_i,
  input  logic [ST_W-1:0]    st_wdata_i,
  output logic               user_o,
  output logic               irq_en_o,
  output logic               prev_user_o,
  output logic               prev_irq_en_o,
  output logic [NUM_CLS-1:0] trap_ind_o,
  output logic               abort_o,
  output logic [PC_W-1:0]    fault_pc_o,
  output logic               redirect_o,
  output logic [PC_W-1:0]    redirect_pc_o
);
  cls_vec_t hit;
  logic     take;
  status_t  st;

  trap_req_collect u_collect (
    .sw_trap_i     (sw_trap_i),
    .unlock_miss_i (unlock_miss_i),
    .fp_fault_i    (fp_fault_i),
    .ifetch_xlat_i (ifetch_xlat_i),
    .ldst_xlat_i   (ldst_xlat_i),
    .misalign_i    (misalign_i),
    .dbg_match_i   (dbg_match_i),
    .ext_irq_i     (ext_irq_i),
    .irq_en_i      (st.im),
    .hit_o         (hit),
    .take_o        (take)
  );

  trap_status_reg u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .take_i   (take),
    .hit_i    (hit),
    .wr_i     (st_wr_i),
    .wdata_i  (status_t'(st_wdata_i)),
    .status_o (st)
  );

  trap_redirect #(.PC_W(PC_W), .HANDLER_VEC(HANDLER_VEC)) u_redirect (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .take_i        (take),
    .pc_i          (pc_i),
    .fault_pc_o    (fault_pc_o),
    .redirect_o    (redirect_o),
    .redirect_pc_o (redirect_pc_o)
  );

  assign abort_o       = take;
  assign user_o        = st.u;
  assign irq_en_o      = st.im;
  assign prev_user_o   = st.pu;
  assign prev_irq_en_o = st.pim;
  assign trap_ind_o    = st.ind;
endmodule

// File: rtl/trap_entry_ctrl_chk.sv
`timescale 1ns/1ps
module trap_entry_ctrl_chk #(
  parameter int PC_W = 32,
  parameter int NC   = 6
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            ext_irq_i,
  input logic            sw_trap_i,
  input logic            unlock_miss_i,
  input logic            fp_fault_i,
  input logic            ifetch_xlat_i,
  input logic            ldst_xlat_i,
  input logic            misalign_i,
  input logic            dbg_match_i,
  input logic [PC_W-1:0] pc_i,
  input logic            st_wr_i,
  input logic            user_o,
  input logic            irq_en_o,
  input logic            prev_user_o,
  input logic            prev_irq_en_o,
  input logic [NC-1:0]   trap_ind_o,
  input logic            abort_o,
  input logic [PC_W-1:0] fault_pc_o,
  input logic            redirect_o
);
  logic other_req;
  assign other_req = sw_trap_i | unlock_miss_i | fp_fault_i | ifetch_xlat_i |
                     ldst_xlat_i | misalign_i | dbg_match_i;

  AST_ENTER_SUPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> (!user_o && !irq_en_o));                                  // R4
  AST_SAVE_PREV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> (prev_user_o == $past(user_o) && prev_irq_en_o == $past(irq_en_o))); // R3
  AST_FAULT_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> (fault_pc_o == $past(pc_i)));                             // R5
  AST_REDIRECT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> redirect_o);                                              // R6
  AST_NO_REDIRECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !abort_o |=> !redirect_o);                                            // R6
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_irq_i && !irq_en_o && !other_req) |-> !abort_o);                 // R8
  AST_IND_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !st_wr_i |=> ((trap_ind_o & $past(trap_ind_o)) == $past(trap_ind_o))); // R10
  AST_REQ_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    other_req |-> abort_o);                                               // R2
endmodule

bind trap_entry_ctrl trap_entry_ctrl_chk #(.PC_W(PC_W), .NC(trap_entry_pkg::NUM_CLS)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ext_irq_i     (ext_irq_i),
  .sw_trap_i     (sw_trap_i),
  .unlock_miss_i (unlock_miss_i),
  .fp_fault_i    (fp_fault_i),
  .ifetch_xlat_i (ifetch_xlat_i),
  .ldst_xlat_i   (ldst_xlat_i),
  .misalign_i    (misalign_i),
  .dbg_match_i   (dbg_match_i),
  .pc_i          (pc_i),
  .st_wr_i       (st_wr_i),
  .user_o        (user_o),
  .irq_en_o      (irq_en_o),
  .prev_user_o   (prev_user_o),
  .prev_irq_en_o (prev_irq_en_o),
  .trap_ind_o    (trap_ind_o),
  .abort_o       (abort_o),
  .fault_pc_o    (fault_pc_o),
  .redirect_o    (redirect_o)
);

// File: tb/trap_entry_ctrl_tb_top.sv
`timescale 1ns/1ps
module trap_entry_ctrl_tb_top;
  localparam int PC_W = 32;
  localparam logic [31:0] VEC = 32'h100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] req = '0;  // {irq, dbg, mis, ldst, ifetch, fp, unlock, sw}
  logic [PC_W-1:0] pc = '0;
  logic st_wr = 1'b0;
  logic [9:0] st_wdata = '0;
  logic user, irq_en, prev_user, prev_irq_en, abort_s, redirect;
  logic [5:0] ind;
  logic [PC_W-1:0] fault_pc, redirect_pc;
  int checks = 0, fails = 0;
  logic done = 1'b0;
  logic last_abort;

  always #2 clk = ~clk;

  trap_entry_ctrl #(.PC_W(PC_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .sw_trap_i(req[0]), .unlock_miss_i(req[1]), .fp_fault_i(req[2]),
    .ifetch_xlat_i(req[3]), .ldst_xlat_i(req[4]), .misalign_i(req[5]),
    .dbg_match_i(req[6]), .ext_irq_i(req[7]), .pc_i(pc),
    .st_wr_i(st_wr), .st_wdata_i(st_wdata),
    .user_o(user), .irq_en_o(irq_en), .prev_user_o(prev_user),
    .prev_irq_en_o(prev_irq_en), .trap_ind_o(ind), .abort_o(abort_s),
    .fault_pc_o(fault_pc), .redirect_o(redirect), .redirect_pc_o(redirect_pc)
  );

  task automatic check(input string req_id, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req_id, act, exp);
    end
  endtask

  task automatic write_status(input logic [9:0] w);
    @(negedge clk); st_wr = 1'b1; st_wdata = w;
    @(posedge clk); #1; st_wr = 1'b0;
  endtask

  task automatic fire(input logic [7:0] r, input logic [31:0] p);
    @(negedge clk); req = r; pc = p;
    #1 last_abort = abort_s;
    @(posedge clk); #1; req = '0;
  endtask

  task automatic t_reset();
    check("R1 user", {31'b0, user}, 0);
    check("R1 irq_en", {31'b0, irq_en}, 0);
    check("R1 prev", {30'b0, prev_user, prev_irq_en}, 0);
    check("R1 ind", {26'b0, ind}, 0);
    check("R1 fault_pc", fault_pc, 0);
    check("R1 abort/redirect", {30'b0, abort_s, redirect}, 0);
  endtask

  task automatic t_sw_trap();
    write_status(10'b00_0000_0011);
    fire(8'h01, 32'h40);
    check("R2 abort", {31'b0, last_abort}, 1);
    check("R4 mode cleared", {30'b0, user, irq_en}, 0);
    check("R3 prev saved", {30'b0, prev_user, prev_irq_en}, 32'h3);
    check("R7 sw bit", {26'b0, ind}, 32'h01);
    check("R5 fault pc", fault_pc, 32'h40);
    check("R6 redirect", {31'b0, redirect}, 1);
    check("R6 vector", redirect_pc, VEC);
    @(posedge clk); #1;
    check("R6 redirect one cycle", {31'b0, redirect}, 0);
    check("R10 sticky", {26'b0, ind}, 32'h01);
    check("R2 no abort idle", {31'b0, abort_s}, 0);
  endtask

  task automatic t_irq_masked();
    write_status(10'b0);
    check("R10 cleared by write", {26'b0, ind}, 0);
    fire(8'h80, 32'h44);
    check("R8 masked no abort", {31'b0, last_abort}, 0);
    check("R8 masked no redirect", {31'b0, redirect}, 0);
    check("R8 masked no ind", {26'b0, ind}, 0);
    check("R8 pc unchanged", fault_pc, 32'h40);
  endtask

  task automatic t_irq_enabled();
    write_status(10'b00_0000_0011);
    fire(8'h80, 32'h48);
    check("R8 accepted abort", {31'b0, last_abort}, 1);
    check("R7 irq bit", {26'b0, ind}, 32'h20);
    check("R4 irq masked after", {31'b0, irq_en}, 0);
    check("R5 fault pc irq", fault_pc, 32'h48);
  endtask

  task automatic t_data_faults();
    for (int k = 4; k <= 6; k++) begin
      write_status(10'b0);
      fire(8'(1 << k), 32'h50 + 32'(k));
      check("R7 data class", {26'b0, ind}, 32'h10);
      check("R2 data abort", {31'b0, last_abort}, 1);
    end
  endtask

  task automatic t_multi();
    write_status(10'b00_0000_0001);
    fire(8'h0F, 32'h60);
    check("R9 union", {26'b0, ind}, 32'h0F);
    check("R9 redirect", {31'b0, redirect}, 1);
    check("R3 prev user", {30'b0, prev_user, prev_irq_en}, 32'h2);
    @(posedge clk); #1;
    check("R9 single redirect", {31'b0, redirect}, 0);
    check("R9 pc", fault_pc, 32'h60);
  endtask

  task automatic t_collide();
    write_status(10'b00_0000_0011);
    @(negedge clk);
    st_wr = 1'b1; st_wdata = 10'b00_0010_0011; req = 8'h04; pc = 32'h70;
    #1 last_abort = abort_s;
    @(posedge clk); #1; st_wr = 1'b0; req = '0;
    check("R11 abort", {31'b0, last_abort}, 1);
    check("R11 mode trap wins", {30'b0, user, irq_en}, 0);
    check("R11 prev pre-edge", {30'b0, prev_user, prev_irq_en}, 32'h3);
    check("R11 ind merge", {26'b0, ind}, 32'h06);
    check("R11 redirect", {31'b0, redirect}, 1);
  endtask

  initial begin
    #7 rst_n = 1'b1;
    #1;
    t_reset();
    t_sw_trap();
    t_irq_masked();
    t_irq_enabled();
    t_data_faults();
    t_multi();
    t_collide();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule